// File: doc/BRIEF.md
# Balanced Priority Data Selector

This block picks one data word out of a set of equally sized words, each paired with a request line. The word it forwards is the one whose request is asserted at the lowest index, so index 0 always wins over all others. It also reports whether any request is asserted and the binary index of the winning request. Typical uses are arbitration front ends, where one of several sources owns a shared path for a cycle, and instruction or packet alignment logic that takes the first valid slot.

The selection is built as a balanced binary tree of 2:1 multiplexers with log2(m) levels, so every data word passes through the same number of multiplexers on its way to the output. Each multiplexer is steered by a "no request in my upper-priority half" term. These terms are formed bottom-up by pairwise AND of inverted requests, so a term at tree level k needs k AND levels and is ready no later than the data arriving at that multiplexer. The winning index is assembled next to the data, one bit per tree level. An optional register stage with synchronous active-high reset sits at the output.

Top module: `prio_mux_sel`

## Requirements
- R1: `valid_o` is 1 exactly when at least one bit of `req_i` is 1.
- R2: When a request is asserted, `grant_idx_o` is the binary index of the lowest-numbered asserted bit of `req_i`.
- R3: `data_o` equals the data word of the granted request; word k occupies bits [k*DATA_W +: DATA_W] of `data_i`.
- R4: Data words of requests that lose, and of non-requesting slots, have no effect on `data_o` while a lower-indexed request is asserted.
- R5: With no request asserted, `valid_o` is 0, `grant_idx_o` is NUM_REQ-1 and `data_o` is the word at index NUM_REQ-1.
- R6: With REG_OUT=1 the outputs reflect the inputs sampled at the previous rising clock edge and hold between edges.
- R7: With REG_OUT=1 a synchronous active-high `rst` clears `valid_o`, `grant_idx_o` and `data_o` to zero at the next rising edge.
- R8: A single request at index 0 or at index NUM_REQ-1 is granted with its own word, and with every request asserted index 0 wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset of the output register stage |
| req_i | input | NUM_REQ | Request lines, bit 0 has the highest priority |
| data_i | input | NUM_REQ*DATA_W | Packed data words, word k at bits [k*DATA_W +: DATA_W] |
| valid_o | output | 1 | At least one request was asserted |
| grant_idx_o | output | $clog2(NUM_REQ) | Index of the winning request |
| data_o | output | DATA_W | Data word of the winning request |

## Verification
The bench builds the block with NUM_REQ=8, DATA_W=8 and REG_OUT=1, which gives a three-level tree where every multiplexer position, including the root fed by the four-request term, is reachable with a handful of patterns. Eight requests keep the full space small enough that random patterns plus a directed table cover lone requests at both ends, dense patterns, the idle fallthrough to the last word and the one-cycle registered timing. Reset is exercised while the outputs hold a nonzero grant.

// File: rtl/prio_sel_pkg.sv
`timescale 1ns/1ps
package prio_sel_pkg;
  function automatic int idx_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
  function automatic bit is_pow2(input int n);
    return (n >= 2) && ((n & (n - 1)) == 0);
  endfunction
endpackage

// File: rtl/pms_none_tree.sv
`timescale 1ns/1ps
// Builds the "no request in this block" terms level by level.
// Level l holds one term per aligned block of 2**l requests.
// The select of a tree node equals the term of its upper-priority half.
module pms_none_tree #(
  parameter int NUM_REQ = 8,
  localparam int LVLS = prio_sel_pkg::idx_width(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] req_i,
  output logic [NUM_REQ-2:0] sel_o,   // level l nodes at offset NUM_REQ-(NUM_REQ>>l)
  output logic               any_o
);
  for (genvar l = 0; l <= LVLS; l++) begin : lv
    localparam int CNT = NUM_REQ >> l;
    logic [CNT-1:0] none;
    if (l == 0) begin : g_leaf
      assign none = ~req_i;
    end else begin : g_pair
      for (genvar n = 0; n < CNT; n++) begin : g_n
        assign none[n] = lv[l-1].none[2*n] & lv[l-1].none[2*n+1];
      end
    end
    if (l < LVLS) begin : g_sel
      localparam int OFS = NUM_REQ - CNT;
      for (genvar n = 0; n < CNT/2; n++) begin : g_s
        assign sel_o[OFS+n] = none[2*n];
      end
    end
  end
  assign any_o = ~lv[LVLS].none[0];
endmodule

// File: rtl/pms_mux_node.sv
`timescale 1ns/1ps
// One 2:1 tree node: passes the lower-index side when sel is 0
// and records the choice as index bit BIT.
module pms_mux_node #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3,
  parameter int BIT    = 0
) (
  input  logic              sel_i,
  input  logic [DATA_W-1:0] d_lo_i,
  input  logic [DATA_W-1:0] d_hi_i,
  input  logic [IDX_W-1:0]  ix_lo_i,
  input  logic [IDX_W-1:0]  ix_hi_i,
  output logic [DATA_W-1:0] d_o,
  output logic [IDX_W-1:0]  ix_o
);
  logic [IDX_W-1:0] mark;
  always_comb begin
    mark      = '0;
    mark[BIT] = sel_i;
  end
  assign d_o  = sel_i ? d_hi_i : d_lo_i;
  assign ix_o = (sel_i ? ix_hi_i : ix_lo_i) | mark;
endmodule

// File: rtl/pms_mux_tree.sv
`timescale 1ns/1ps
// Balanced multiplexer tree: every word crosses exactly LVLS nodes.
module pms_mux_tree #(
  parameter int NUM_REQ = 8,
  parameter int DATA_W  = 8,
  localparam int LVLS  = prio_sel_pkg::idx_width(NUM_REQ),
  localparam int IDX_W = LVLS
) (
  input  logic [NUM_REQ-2:0]        sel_i,
  input  logic [NUM_REQ*DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]         data_o,
  output logic [IDX_W-1:0]          idx_o
);
  for (genvar l = 0; l < LVLS; l++) begin : lv
    localparam int NODES = NUM_REQ >> (l + 1);
    localparam int OFS   = NUM_REQ - (NUM_REQ >> l);
    logic [NODES*DATA_W-1:0] d;
    logic [NODES*IDX_W-1:0]  ix;
    for (genvar n = 0; n < NODES; n++) begin : g_n
      logic [DATA_W-1:0] lo_d, hi_d;
      logic [IDX_W-1:0]  lo_ix, hi_ix;
      if (l == 0) begin : g_src
        assign lo_d  = data_i[(2*n)*DATA_W +: DATA_W];
        assign hi_d  = data_i[(2*n+1)*DATA_W +: DATA_W];
        assign lo_ix = '0;
        assign hi_ix = '0;
      end else begin : g_chain
        assign lo_d  = lv[l-1].d[(2*n)*DATA_W +: DATA_W];
        assign hi_d  = lv[l-1].d[(2*n+1)*DATA_W +: DATA_W];
        assign lo_ix = lv[l-1].ix[(2*n)*IDX_W +: IDX_W];
        assign hi_ix = lv[l-1].ix[(2*n+1)*IDX_W +: IDX_W];
      end
      pms_mux_node #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BIT(l)) node_i (
        .sel_i   (sel_i[OFS+n]),
        .d_lo_i  (lo_d),
        .d_hi_i  (hi_d),
        .ix_lo_i (lo_ix),
        .ix_hi_i (hi_ix),
        .d_o     (d[n*DATA_W +: DATA_W]),
        .ix_o    (ix[n*IDX_W +: IDX_W])
      );
    end
  end
  assign data_o = lv[LVLS-1].d;
  assign idx_o  = lv[LVLS-1].ix;
endmodule

// File: rtl/prio_mux_sel.sv
`timescale 1ns/1ps
module prio_mux_sel #(
  parameter int NUM_REQ = 8,
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W = prio_sel_pkg::idx_width(NUM_REQ)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_REQ-1:0]        req_i,
  input  logic [NUM_REQ*DATA_W-1:0] data_i,
  output logic                      valid_o,
  output logic [IDX_W-1:0]          grant_idx_o,
  output logic [DATA_W-1:0]         data_o
);
  initial begin
    if (!prio_sel_pkg::is_pow2(NUM_REQ))
      $error("NUM_REQ must be a power of two of at least 2");
  end

  logic [NUM_REQ-2:0] sel;
  logic               any;
  logic [DATA_W-1:0]  win_d;
  logic [IDX_W-1:0]   win_ix;

  pms_none_tree #(.NUM_REQ(NUM_REQ)) terms_i (
    .req_i (req_i),
    .sel_o (sel),
    .any_o (any)
  );

  pms_mux_tree #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) tree_i (
    .sel_i  (sel),
    .data_i (data_i),
    .data_o (win_d),
    .idx_o  (win_ix)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_o     <= 1'b0;
        grant_idx_o <= '0;
        data_o      <= '0;
      end else begin
        valid_o     <= any;
        grant_idx_o <= win_ix;
        data_o      <= win_d;
      end
    end
  end else begin : g_comb
    assign valid_o     = any;
    assign grant_idx_o = win_ix;
    assign data_o      = win_d;
  end
endmodule

// File: rtl/prio_mux_sel_chk.sv
`timescale 1ns/1ps
module prio_mux_sel_chk #(
  parameter int NUM_REQ = 8,
  parameter int DATA_W  = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int IDX_W = prio_sel_pkg::idx_width(NUM_REQ)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_REQ-1:0]        req_i,
  input logic [NUM_REQ*DATA_W-1:0] data_i,
  input logic                      valid_o,
  input logic [IDX_W-1:0]          grant_idx_o,
  input logic [DATA_W-1:0]         data_o
);
  logic [NUM_REQ-1:0]        req_d;
  logic [NUM_REQ*DATA_W-1:0] data_d;
  logic                      primed;
  logic [NUM_REQ-1:0]        req_v;
  logic [NUM_REQ*DATA_W-1:0] data_v;
  logic [NUM_REQ-1:0]        below;

  always_ff @(posedge clk) begin
    req_d  <= req_i;
    data_d <= data_i;
    primed <= !rst;
  end

  assign req_v  = REG_OUT ? req_d  : req_i;
  assign data_v = REG_OUT ? data_d : data_i;
  assign below  = (NUM_REQ'(1) << grant_idx_o) - NUM_REQ'(1);

  a_r1_valid_is_any: assert property (@(posedge clk) disable iff (rst)
    primed |-> (valid_o == (|req_v)));
  a_r2_grant_requested: assert property (@(posedge clk) disable iff (rst)
    (primed && valid_o) |-> req_v[grant_idx_o]);
  a_r2_no_lower_request: assert property (@(posedge clk) disable iff (rst)
    (primed && valid_o) |-> ((req_v & below) == '0));
  a_r3_data_of_winner: assert property (@(posedge clk) disable iff (rst)
    (primed && valid_o) |-> (data_o == data_v[grant_idx_o*DATA_W +: DATA_W]));
  a_r5_idle_last_word: assert property (@(posedge clk) disable iff (rst)
    (primed && !valid_o) |-> ((grant_idx_o == IDX_W'(NUM_REQ-1)) &&
                              (data_o == data_v[(NUM_REQ-1)*DATA_W +: DATA_W])));
  if (REG_OUT) begin : g_regchk
    a_r7_reset_clears: assert property (@(posedge clk)
      rst |=> (!valid_o && grant_idx_o == '0 && data_o == '0));
  end
endmodule

bind prio_mux_sel prio_mux_sel_chk #(
  .NUM_REQ(NUM_REQ), .DATA_W(DATA_W), .REG_OUT(REG_OUT)
) chk_i (
  .clk(clk), .rst(rst), .req_i(req_i), .data_i(data_i),
  .valid_o(valid_o), .grant_idx_o(grant_idx_o), .data_o(data_o)
);

// File: tb/prio_mux_sel_tb_top.sv
`timescale 1ns/1ps
module prio_mux_sel_tb_top;
  localparam int N  = 8;
  localparam int W  = 8;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   req_i = '0;
  logic [N*W-1:0] data_i = '0;
  logic           valid_o;
  logic [IW-1:0]  grant_idx_o;
  logic [W-1:0]   data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  prio_mux_sel #(.NUM_REQ(N), .DATA_W(W), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .data_i(data_i),
    .valid_o(valid_o), .grant_idx_o(grant_idx_o), .data_o(data_o)
  );

  // {req, exp_valid, exp_idx}; expected data is 8'hA0 + idx
  localparam logic [11:0] VEC [10] = '{
    {8'b0000_0001, 1'b1, 3'd0},
    {8'b1000_0000, 1'b1, 3'd7},
    {8'b0110_0100, 1'b1, 3'd2},
    {8'b1111_1111, 1'b1, 3'd0},
    {8'b1111_1110, 1'b1, 3'd1},
    {8'b1010_0000, 1'b1, 3'd5},
    {8'b0001_0000, 1'b1, 3'd4},
    {8'b1100_0000, 1'b1, 3'd6},
    {8'b0000_1000, 1'b1, 3'd3},
    {8'b0000_0000, 1'b0, 3'd7}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_words();
    for (int k = 0; k < N; k++) data_i[k*W +: W] = 8'hA0 + 8'(k);
  endtask

  task automatic apply(input logic [N-1:0] r);
    @(negedge clk);
    req_i = r;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    load_words();
    req_i = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    // R7: outputs cleared while reset is held
    check("R7 reset valid", 32'(valid_o), 32'd0);
    check("R7 reset idx", 32'(grant_idx_o), 32'd0);
    check("R7 reset data", 32'(data_o), 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1 R2 R3 R5 R8: table walk
    for (int v = 0; v < 10; v++) begin
      apply(VEC[v][11:4]);
      check("R1 valid", 32'(valid_o), 32'(VEC[v][3]));
      check("R2 grant index", 32'(grant_idx_o), 32'(VEC[v][2:0]));
      check("R3 data word", 32'(data_o), 32'(8'hA0 + 8'(VEC[v][2:0])));
    end
    // R5 idle result stated explicitly
    apply('0);
    check("R5 idle valid", 32'(valid_o), 32'd0);
    check("R5 idle index", 32'(grant_idx_o), 32'd7);
    check("R5 idle data", 32'(data_o), 32'hA7);

    // R4: losing words do not matter
    apply(8'b0110_0100);
    @(negedge clk);
    data_i[5*W +: W] = 8'h11;
    data_i[6*W +: W] = 8'h22;
    data_i[7*W +: W] = 8'h33;
    data_i[0*W +: W] = 8'h44;
    @(posedge clk); #1;
    check("R4 losers ignored", 32'(data_o), 32'hA2);
    // R3: winning word change is followed
    @(negedge clk);
    data_i[2*W +: W] = 8'h5C;
    @(posedge clk); #1;
    check("R3 winner word tracked", 32'(data_o), 32'h5C);
    load_words();

    // R6: one-cycle registered timing
    apply(8'b0000_0010);
    @(negedge clk);
    req_i = 8'b1000_0000;
    #1;
    check("R6 hold before edge", 32'(grant_idx_o), 32'd1);
    @(posedge clk); #1;
    check("R6 update after edge", 32'(grant_idx_o), 32'd7);

    // R1 R2 R3: random patterns against a behavioural search
    for (int t = 0; t < 300; t++) begin
      logic [N-1:0] r;
      int win;
      r = N'($urandom);
      if (t % 3 == 0) r = r & N'($urandom);
      for (int k = 0; k < N; k++) data_i[k*W +: W] = W'($urandom);
      win = N - 1;
      for (int k = N - 1; k >= 0; k--) if (r[k]) win = k;
      apply(r);
      check("R1 random valid", 32'(valid_o), 32'(|r));
      check("R2 random index", 32'(grant_idx_o), 32'(win));
      check("R3 random data", 32'(data_o), 32'(data_i[win*W +: W]));
    end

    // R7: reset while a grant is held
    load_words();
    apply(8'b0100_0000);
    check("R7 pre-reset index", 32'(grant_idx_o), 32'd6);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check("R7 reset valid", 32'(valid_o), 32'd0);
    check("R7 reset index", 32'(grant_idx_o), 32'd0);
    check("R7 reset data", 32'(data_o), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    apply(8'b0100_0000);
    check("R8 after reset index", 32'(grant_idx_o), 32'd6);

    done = 1'b1;
    finish_run();
  end
endmodule